// File: doc/BRIEF.md
# Calibrated Frame-Windowed Phase Averager

This block sits after a zero-crossing tracking loop that emits a 7-bit phase index every sample clock. Each index counts delay taps, and one period holds 128 taps. The block opens a measurement window on a frame-start pulse and takes a programmed number of valid samples. It corrects every sample through a per-code calibration table that cancels the repeatable nonlinearity of the delay taps and the tap selector. When the window closes, it divides the running sum by the sample count and reports the mean phase. The result has eight fractional bits, so averaging dithered codes gives an estimate finer than one tap.

Codes that dither across the 127/0 boundary would spoil a plain average. Each sample is therefore unwrapped against the first sample of its window before it is summed. The final mean is folded back into one period. Software loads the calibration table through an address/data write port. Windows of up to 2^21 samples are supported, which covers about one million samples taken over a 10 ms slot of a 100 ms frame.

Top module: `phase_avg_top`

## Requirements
- R1: After reset, mean_o is 0 and mean_valid_o is 0. The block is idle and every calibration entry is 0.
- R2: A cycle with cal_we_i high writes cal_data_i into entry cal_addr_i. The entry is a two's-complement value in units of 1/256 tap. The corrected value of code c is c*256 plus entry c. A sample in the same cycle as a write to its own code uses the old entry.
- R3: When the block is idle, a frame_start_i pulse opens a window and latches win_len_i as N. A win_len_i of 0 is taken as 1. A sample in the frame-start cycle is not counted. Only cycles with sample_valid_i high are counted, and the window closes on its N-th counted sample.
- R4: The first sample of a window is the reference r. A later code k with k-r > 64 counts as k-128. A later code with k-r < -64 counts as k+128. Any other code counts as k.
- R5: mean_o = floor(S/N) mod 32768, where S is the sum over the window of (unwrapped code + 128)*256 + calibration entry. Bits [14:8] hold the integer tap and bits [7:0] hold the fraction.
- R6: mean_valid_o is high for exactly one cycle. It is seen 18 clock edges after the edge that accepted the last sample of the window.
- R7: The sum does not overflow for any N up to 2^21, including codes that all carry the largest positive correction.
- R8: While a window is open, or while the divide runs, frame_start_i pulses are ignored. Samples during the divide are also ignored. A new window opens only on a frame-start pulse after the strobe.
- R9: mean_o changes only together with mean_valid_o and holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_we_i | input | 1 | Calibration table write enable |
| cal_addr_i | input | 7 | Calibration entry to write |
| cal_data_i | input | 10 | Signed correction, 1/256 tap units |
| frame_start_i | input | 1 | Frame start pulse, opens a window when idle |
| win_len_i | input | 22 | Samples per window (0 treated as 1) |
| sample_valid_i | input | 1 | code_i carries a sample this cycle |
| code_i | input | 7 | Phase index in delay taps |
| mean_o | output | 15 | Mean phase, 7 integer and 8 fraction bits |
| mean_valid_o | output | 1 | One-cycle strobe for a new mean_o |

## Verification
The assertions check these rules on every cycle:
- The strobe is a single cycle and follows only a divide.
- mean_o never moves without the strobe.
- The sum never decreases inside a window, which is how a wraparound of the sum would show.
- The sample count stays below N.
- The divider remainder stays below the divisor.
- No state moves while the divide is running.

Only the bench scenarios can show the numeric results:
- The unwrap decision at the ±64 boundary and the fold of means that land below 0 or above 128.
- A calibration entry changing the mean by the right fraction.
- The exact 18-cycle latency.
- Frame pulses that arrive during a window or a divide being dropped.

// File: rtl/phase_avg_pkg.sv
package phase_avg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DIV} avg_state_e;
endpackage

// File: rtl/phase_cal_table.sv
module phase_cal_table #(
  parameter int CODE_W = 7,
  parameter int CAL_W  = 10,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [CAL_W-1:0]  wdata_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [CAL_W-1:0]  rdata_o
);
  logic [CAL_W-1:0] mem_q [NCODES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCODES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read before write: a same-cycle write lands after the read
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/phase_unwrap.sv
module phase_unwrap #(
  parameter int CODE_W = 7,
  parameter int FRAC_W = 8,
  parameter int CAL_W  = 10,
  localparam int SAMP_W = CODE_W + FRAC_W + 2,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] ref_i,
  input  logic              first_i,
  input  logic [CAL_W-1:0]  cal_i,
  output logic [SAMP_W-1:0] samp_o
);
  localparam logic signed [CODE_W+1:0] HALF_S = (CODE_W+2)'(NCODES / 2);

  logic [CODE_W-1:0]        ref_eff;
  logic signed [CODE_W+1:0] diff;
  logic [CODE_W+1:0]        k_off;
  logic [SAMP_W-1:0]        cal_ext;

  assign ref_eff = first_i ? code_i : ref_i;
  assign diff    = $signed({2'b00, code_i}) - $signed({2'b00, ref_eff});

  // unwrapped code plus one period offset, always non-negative
  always_comb begin
    if (diff > HALF_S)       k_off = {2'b00, code_i};
    else if (diff < -HALF_S) k_off = {2'b00, code_i} + (CODE_W+2)'(2 * NCODES);
    else                     k_off = {2'b00, code_i} + (CODE_W+2)'(NCODES);
  end

  assign cal_ext = SAMP_W'($signed(cal_i));
  assign samp_o  = {k_off, {FRAC_W{1'b0}}} + cal_ext;
endmodule

// File: rtl/phase_seq_div.sv
module phase_seq_div #(
  parameter int DIVD_W = 38,
  parameter int DVS_W  = 22,
  parameter int Q_W    = 17,
  parameter int OUT_W  = 15,
  localparam int CW    = $clog2(Q_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0]  divisor_i,
  output logic              done_o,
  output logic [OUT_W-1:0]  quot_o
);
  logic [DVS_W:0]   rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [Q_W-1:0]   sh_q;
  logic [OUT_W-1:0] quot_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [DVS_W:0]   trial;
  logic             take;

  // dividend < divisor * 2^Q_W, so the top part starts below the divisor
  assign trial = {rem_q[DVS_W-1:0], sh_q[Q_W-1]};
  assign take  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      sh_q   <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= (DVS_W+1)'(dividend_i[DIVD_W-1:Q_W]);
        sh_q   <= dividend_i[Q_W-1:0];
        dvs_q  <= divisor_i;
        quot_q <= '0;
        cnt_q  <= CW'(Q_W);
      end else if (cnt_q != '0) begin
        rem_q  <= take ? trial - {1'b0, dvs_q} : trial;
        sh_q   <= {sh_q[Q_W-2:0], 1'b0};
        quot_q <= {quot_q[OUT_W-2:0], take};
        cnt_q  <= cnt_q - CW'(1);
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;

  assert_rem_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/phase_avg_top.sv
module phase_avg_top #(
  parameter int CODE_W = 7,
  parameter int FRAC_W = 8,
  parameter int CAL_W  = 10,
  parameter int WIN_W  = 22,
  localparam int SAMP_W = CODE_W + FRAC_W + 2,
  localparam int ACC_W  = SAMP_W + WIN_W - 1,
  localparam int MEAN_W = CODE_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_we_i,
  input  logic [CODE_W-1:0] cal_addr_i,
  input  logic [CAL_W-1:0]  cal_data_i,
  input  logic              frame_start_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [MEAN_W-1:0] mean_o,
  output logic              mean_valid_o
);
  import phase_avg_pkg::*;

  avg_state_e        state_q;
  logic [ACC_W-1:0]  acc_q;
  logic [WIN_W-1:0]  cnt_q, n_q;
  logic [CODE_W-1:0] ref_q;
  logic [MEAN_W-1:0] mean_q;
  logic              valid_q;

  logic [CAL_W-1:0]  cal_rd;
  logic [SAMP_W-1:0] samp;
  logic [ACC_W-1:0]  acc_nxt;
  logic              accept, last, first;
  logic              div_done;
  logic [MEAN_W-1:0] div_quot;

  assign accept  = (state_q == ST_ACC) && sample_valid_i;
  assign first   = (cnt_q == '0);
  assign last    = accept && ((cnt_q + WIN_W'(1)) == n_q);
  assign acc_nxt = acc_q + ACC_W'(samp);

  phase_cal_table #(.CODE_W(CODE_W), .CAL_W(CAL_W)) u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cal_we_i),
    .waddr_i (cal_addr_i),
    .wdata_i (cal_data_i),
    .raddr_i (code_i),
    .rdata_o (cal_rd)
  );

  phase_unwrap #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .CAL_W(CAL_W)) u_unwrap (
    .code_i  (code_i),
    .ref_i   (ref_q),
    .first_i (first),
    .cal_i   (cal_rd),
    .samp_o  (samp)
  );

  phase_seq_div #(.DIVD_W(ACC_W), .DVS_W(WIN_W), .Q_W(SAMP_W), .OUT_W(MEAN_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (last),
    .dividend_i (acc_nxt),
    .divisor_i  (n_q),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      cnt_q   <= '0;
      n_q     <= WIN_W'(1);
      ref_q   <= '0;
      mean_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (frame_start_i) begin
          state_q <= ST_ACC;
          acc_q   <= '0;
          cnt_q   <= '0;
          n_q     <= (win_len_i == '0) ? WIN_W'(1) : win_len_i;
        end
        ST_ACC: if (accept) begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + WIN_W'(1);
          if (first) ref_q <= code_i;
          if (last) state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          mean_q  <= div_quot;  // low bits of the quotient fold into one period
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mean_o       = mean_q;
  assign mean_valid_o = valid_q;

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_after_div_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(state_q == ST_DIV));
  assert_mean_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mean_q) |-> valid_q);
  assert_acc_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !first) |=> (acc_q >= $past(acc_q)));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC) |-> (cnt_q < n_q));
  assert_div_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV) |=> ($stable(acc_q) && $stable(cnt_q) && $stable(n_q)));
endmodule

// File: tb/sim_phase_avg_top.sv
module sim_phase_avg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cal_we_i = 1'b0;
  logic [6:0]  cal_addr_i = '0;
  logic [9:0]  cal_data_i = '0;
  logic        frame_start_i = 1'b0;
  logic [21:0] win_len_i = '0;
  logic        sample_valid_i = 1'b0;
  logic [6:0]  code_i = '0;
  logic [14:0] mean_o;
  logic        mean_valid_o;

  phase_avg_top u0 (.*);

  always #5 clk_i = ~clk_i;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference model
  int     cal_m [128];
  int     mstate = 0;          // 0 idle, 1 window, 2 dividing
  longint sum_m = 0;
  int     cnt_m = 0, n_m = 1, ref_m = 0;
  longint cyc = 0, due = -1;
  int     mean_m = 0;

  initial for (int i = 0; i < 128; i++) cal_m[i] = 0;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (mstate == 2) begin
        if (cyc == due) mstate = 0;
      end else if (mstate == 0) begin
        if (frame_start_i) begin
          mstate = 1; sum_m = 0; cnt_m = 0;
          n_m = (win_len_i == 0) ? 1 : int'(win_len_i);
        end
      end else if (sample_valid_i) begin
        int k, c;
        c = int'(code_i);
        if (cnt_m == 0) ref_m = c;
        k = c;
        if (c - ref_m > 64) k = c - 128;
        else if (c - ref_m < -64) k = c + 128;
        sum_m += longint'((k + 128) * 256 + cal_m[c]);
        cnt_m++;
        if (cnt_m == n_m) begin
          mstate = 2; due = cyc + 18;
          mean_m = int'((sum_m / longint'(n_m)) % 32768);
        end
      end
      if (cal_we_i) cal_m[cal_addr_i] = int'($signed(cal_data_i));
    end
  end

  // compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit exp_v;
      exp_v = (cyc == due);
      n_cmp++;
      if (mean_valid_o !== exp_v) begin
        n_bad++;
        $display("FAIL %s/R6 mean_valid_o at cycle %0d: got %0b exp %0b", cur_req, cyc, mean_valid_o, exp_v);
      end
      n_cmp++;
      if (int'(mean_o) != (cyc >= due && due >= 0 ? mean_m : last_mean)) begin
        n_bad++;
        $display("FAIL %s/R5/R9 mean_o at cycle %0d: got %0d exp %0d", cur_req, cyc, mean_o,
                 (cyc >= due && due >= 0) ? mean_m : last_mean);
      end
    end
  end

  // last published mean, for the hold check before a pending result lands
  int last_mean = 0;
  always @(negedge clk_i) if (rst_ni && cyc == due) last_mean <= mean_m;

  task automatic tick(bit fs, bit v, int code);
    @(negedge clk_i);
    frame_start_i = fs; sample_valid_i = v; code_i = 7'(code);
    cal_we_i = 1'b0;
  endtask

  task automatic cal_wr(int a, int d);
    @(negedge clk_i);
    frame_start_i = 0; sample_valid_i = 0;
    cal_we_i = 1'b1; cal_addr_i = 7'(a); cal_data_i = 10'(d);
  endtask

  task automatic open_win(int n);
    @(negedge clk_i);
    cal_we_i = 0; sample_valid_i = 0;
    win_len_i = 22'(n); frame_start_i = 1;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) tick(0, 0, 0);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if (mean_o !== '0 || mean_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got %0d/%0b exp 0/0", mean_o, mean_valid_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R3 R5: plain average with fraction, 10,10,11,11 -> 10.5
    cur_req = "R3";
    open_win(4);
    tick(0, 1, 10); tick(0, 1, 10); tick(0, 1, 11); tick(0, 1, 11);
    idle(22);

    // R3: frame-start cycle sample not counted, gaps in valid
    open_win(3);
    tick(1, 1, 90);
    tick(0, 1, 20); tick(0, 0, 99); tick(0, 1, 21); tick(0, 0, 0); tick(0, 1, 23);
    idle(22);

    // R2: calibration entries, including write during a same-code sample
    cur_req = "R2";
    cal_wr(40, 100); cal_wr(41, -37); cal_wr(42, 511); cal_wr(43, -512);
    open_win(5);
    tick(0, 1, 40); tick(0, 1, 41); tick(0, 1, 42); tick(0, 1, 43);
    @(negedge clk_i);
    sample_valid_i = 1; code_i = 7'd40; cal_we_i = 1; cal_addr_i = 7'd40; cal_data_i = 10'd7;
    idle(22);

    // R4: wrap across 127/0 starting high; R5 fold
    cur_req = "R4";
    open_win(4);
    tick(0, 1, 126); tick(0, 1, 1); tick(0, 1, 127); tick(0, 1, 0);
    idle(22);
    // R4: starting low, mean below zero folds upward
    open_win(3);
    tick(0, 1, 1); tick(0, 1, 127); tick(0, 1, 126);
    idle(22);
    // R4: exactly +64 and +65 from the reference
    open_win(3);
    tick(0, 1, 10); tick(0, 1, 74); tick(0, 1, 75);
    idle(22);
    // R4: exactly -64 and -65 from the reference
    open_win(3);
    tick(0, 1, 100); tick(0, 1, 36); tick(0, 1, 35);
    idle(22);

    // R8: frame pulses in window and in divide; samples in divide ignored
    cur_req = "R8";
    open_win(3);
    tick(0, 1, 5); win_len_i = 22'd1; tick(1, 1, 6); tick(0, 1, 9);
    for (int i = 0; i < 17; i++) tick(i == 3 || i == 16, 1, 127);
    tick(1, 1, 60);
    tick(0, 1, 61);
    idle(22);

    // R3: window length 0 taken as 1
    cur_req = "R3";
    open_win(0);
    tick(0, 1, 77);
    idle(22);

    // R7: long window of the largest corrected value
    cur_req = "R7";
    cal_wr(127, 511);
    open_win(40000);
    for (int i = 0; i < 40000; i++) tick(0, 1, 127);
    idle(22);

    // R6 R9: hold between results
    cur_req = "R9";
    idle(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule